// File: doc/BRIEF.md
# Accumulation Interval Sequencer

This block paces a sampling compute engine and tells a host processor when there is work to collect. A strobe that arrives at the rate of a 32768 Hz clock is divided by thirteen to mark the start of each sample period, giving about 2520.6 sample periods per second. At the start of each period the block raises a compute-busy strobe for a fixed number of cycles. It counts sample periods into groups and groups into an accumulation interval. When the final sample of an interval has been processed, it raises a transfer-busy strobe, which tells the host that fresh results are being written out.

The length of an interval is the product of two host settings. One is a plain group count. The other is a two-bit code for the group size, where the size is 42 samples shifted left by the code. With 60 groups of 42 samples, an interval holds 2520 samples. That is about 999.75 ms, so it is near one second but not exactly one second.

Each busy strobe has a sticky interrupt flag. The flag is set by the falling edge of the strobe and cleared by a write-one-to-clear access from the host. All pins are plain control and status levels or one-cycle strobes. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `acc_interval_seq`

## Requirements
- R1: A sample period begins on every thirteenth clock in which `tick_32k` is high while `enable` is high. The first period begins on the first such tick after `enable` rises. `compute_busy` goes high on the clock edge at which a period begins.
- R2: `compute_busy` stays high for exactly 4 clock cycles in each sample period, unless `enable` drops first.
- R3: An interval holds G × S sample periods. G is `grp_count`. S is 42, 84, 168 or 336 for `grp_size_sel` = 0, 1, 2 or 3 respectively.
- R4: A `grp_count` of 0 behaves as a group count of 1.
- R5: `xfer_busy` rises on the edge at which `compute_busy` of an interval's final sample falls. It then stays high for exactly 2 cycles.
- R6: Bit 0 of `irq_flags` belongs to `compute_busy` and bit 1 to `xfer_busy`. A flag becomes 1 on the edge after the one at which its strobe went from 1 to 0, including a drop caused by clearing `enable`. A rising edge of a strobe never sets a flag.
- R7: A cycle with `clr_wr` = 1 clears, on its closing edge, every flag whose bit in `clr_bits` is 1. Flags whose bit is 0 are left as they are.
- R8: If a clear and a new falling edge for the same flag meet in one cycle, the flag stays set.
- R9: After reset, and within one edge after `enable` goes low, both strobes are low and the sample and group counts are zero. While `enable` is low, no sample period starts. After `enable` is set again, a full interval is counted from the beginning.
- R10: `irq` is high exactly when at least one bit of `irq_flags` is set.
- R11: While `enable` stays high, intervals follow one another without a gap, and each one has the length given by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low holds the sequencer idle |
| tick_32k | input | 1 | One-cycle strobe at the 32768 Hz rate |
| grp_count | input | SUM_W | Number of groups per interval (0 acts as 1) |
| grp_size_sel | input | 2 | Group size code: 42 samples shifted left by the code |
| compute_busy | output | 1 | High while the current sample period is processed |
| xfer_busy | output | 1 | High while interval results are written out |
| clr_wr | input | 1 | Host write strobe for flag clearing |
| clr_bits | input | 2 | Write-one-to-clear mask for the flags |
| irq_flags | output | 2 | Sticky flags: bit 0 compute, bit 1 transfer |
| irq | output | 1 | OR of the sticky flags |

## Verification
The bound checker checks on every cycle that both strobes fall within one edge of `enable` dropping, and that each strobe survives its first cycle. It also checks that the transfer strobe only starts as the compute strobe ends, that every falling edge sets its flag, that a flag only rises after a 1-to-0 step, and that a clear without a coincident falling edge removes the flag. The bench's scenarios are needed for the quantities that span many cycles. These are the exact sample count of an interval for each size code and for a zero group count, the spacing of sample periods for dense and sparse ticks, the exact widths of both strobes, restart from zero after a pause, and the clear that collides with a falling edge.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  // Index of each interrupt source inside the flag vector.
  localparam int unsigned IRQ_COMP = 0;
  localparam int unsigned IRQ_XFER = 1;
  localparam int unsigned N_IRQ    = 2;

  // Group size code: base group length shifted left by the code.
  typedef enum logic [1:0] {
    GSZ_X1 = 2'd0,
    GSZ_X2 = 2'd1,
    GSZ_X4 = 2'd2,
    GSZ_X8 = 2'd3
  } grp_size_e;

  localparam int unsigned GSZ_MAX_SHIFT = 3;

endpackage

// File: rtl/acc_sample_timebase.sv
module acc_sample_timebase #(
  parameter int unsigned TICKS_PER_SAMPLE = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic sample_start
);

  localparam int unsigned CW = (TICKS_PER_SAMPLE > 1) ? $clog2(TICKS_PER_SAMPLE) : 1;
  localparam logic [CW-1:0] LAST_PHASE = CW'(TICKS_PER_SAMPLE - 1);

  logic [CW-1:0] phase;

  // Phase counts slow-clock ticks inside one sample period.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase <= '0;
    end else if (tick) begin
      phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end
  end

  assign sample_start = enable & tick & (phase == '0);

endmodule

// File: rtl/acc_busy_timer.sv
module acc_busy_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load,
  output logic busy,
  output logic last_beat
);

  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LEN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      remain <= '0;
    end else if (load) begin
      remain <= LOAD_VAL;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy      = (remain != '0);
  // High in the last busy cycle; the strobe drops at the closing edge.
  assign last_beat = enable & (remain == CW'(1)) & ~load;

endmodule

// File: rtl/acc_interval_counter.sv
module acc_interval_counter
  import acc_seq_pkg::*;
#(
  parameter int unsigned BASE_SAMPLES = 42,
  parameter int unsigned SUM_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sample_start,
  input  logic [SUM_W-1:0] grp_count,
  input  logic [1:0]       grp_size_sel,
  output logic             interval_end
);

  localparam int unsigned MAX_LEN = BASE_SAMPLES << GSZ_MAX_SHIFT;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] BASE_LEN = LEN_W'(BASE_SAMPLES);

  grp_size_e        size_code;
  logic [LEN_W-1:0] grp_len;
  logic [LEN_W-1:0] samp_idx;
  logic [SUM_W-1:0] grp_idx;
  logic [SUM_W-1:0] grp_eff;
  logic             last_samp;
  logic             last_grp;

  assign size_code = grp_size_e'(grp_size_sel);

  always_comb begin
    unique case (size_code)
      GSZ_X1:  grp_len = BASE_LEN;
      GSZ_X2:  grp_len = BASE_LEN << 1;
      GSZ_X4:  grp_len = BASE_LEN << 2;
      default: grp_len = BASE_LEN << 3;
    endcase
  end

  assign grp_eff   = (grp_count == '0) ? SUM_W'(1) : grp_count;
  // Compare with >= so a setting changed mid-interval cannot overrun.
  assign last_samp = (samp_idx >= grp_len - 1'b1);
  assign last_grp  = (grp_idx >= grp_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      samp_idx <= '0;
      grp_idx  <= '0;
    end else if (sample_start) begin
      if (last_samp) begin
        samp_idx <= '0;
        grp_idx  <= last_grp ? '0 : grp_idx + 1'b1;
      end else begin
        samp_idx <= samp_idx + 1'b1;
      end
    end
  end

  assign interval_end = sample_start & last_samp & last_grp;

endmodule

// File: rtl/acc_irq_edge_flag.sv
module acc_irq_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic clr,
  output logic flag
);

  logic busy_q;
  logic fall;

  assign fall = busy_q & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      busy_q <= busy;
      // A fresh falling edge outranks a clear in the same cycle.
      flag   <= fall | (flag & ~clr);
    end
  end

endmodule

// File: rtl/acc_interval_seq.sv
module acc_interval_seq
  import acc_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_SAMPLE = 13,
  parameter int unsigned BASE_SAMPLES     = 42,
  parameter int unsigned SUM_W            = 8,
  parameter int unsigned COMP_BUSY_LEN    = 4,
  parameter int unsigned XFER_BUSY_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick_32k,
  input  logic [SUM_W-1:0] grp_count,
  input  logic [1:0]       grp_size_sel,
  output logic             compute_busy,
  output logic             xfer_busy,
  input  logic             clr_wr,
  input  logic [1:0]       clr_bits,
  output logic [1:0]       irq_flags,
  output logic             irq
);

  logic sample_start;
  logic interval_end;
  logic comp_last;
  logic xfer_last_unused;
  logic xfer_pending;
  logic xfer_load;
  logic [N_IRQ-1:0] busy_vec;

  acc_sample_timebase #(.TICKS_PER_SAMPLE(TICKS_PER_SAMPLE)) u_timebase (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .tick         (tick_32k),
    .sample_start (sample_start)
  );

  acc_interval_counter #(.BASE_SAMPLES(BASE_SAMPLES), .SUM_W(SUM_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_start (sample_start),
    .grp_count    (grp_count),
    .grp_size_sel (grp_size_sel),
    .interval_end (interval_end)
  );

  acc_busy_timer #(.LEN(COMP_BUSY_LEN)) u_comp_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load      (sample_start),
    .busy      (compute_busy),
    .last_beat (comp_last)
  );

  // The final sample of an interval arms the transfer; it launches as
  // that sample's compute strobe ends.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      xfer_pending <= 1'b0;
    end else if (interval_end) begin
      xfer_pending <= 1'b1;
    end else if (comp_last) begin
      xfer_pending <= 1'b0;
    end
  end

  assign xfer_load = comp_last & xfer_pending;

  acc_busy_timer #(.LEN(XFER_BUSY_LEN)) u_xfer_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load      (xfer_load),
    .busy      (xfer_busy),
    .last_beat (xfer_last_unused)
  );

  assign busy_vec[IRQ_COMP] = compute_busy;
  assign busy_vec[IRQ_XFER] = xfer_busy;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    acc_irq_edge_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (busy_vec[i]),
      .clr   (clr_wr & clr_bits[i]),
      .flag  (irq_flags[i])
    );
  end

  assign irq = |irq_flags;

endmodule

// File: rtl/acc_interval_seq_chk.sv
module acc_interval_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       compute_busy,
  input logic       xfer_busy,
  input logic       clr_wr,
  input logic [1:0] clr_bits,
  input logic [1:0] irq_flags
);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!compute_busy && !xfer_busy)); // R9

  AST_COMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(compute_busy) && enable) |=> compute_busy); // R2

  AST_XFER_FOLLOWS_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> $fell(compute_busy)); // R5

  AST_XFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xfer_busy) && enable) |=> xfer_busy); // R5

  AST_COMP_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(compute_busy) |=> irq_flags[0]); // R6

  AST_XFER_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |=> irq_flags[1]); // R6

  AST_COMP_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[0]) |-> ($past(compute_busy, 2) && !$past(compute_busy))); // R6

  AST_XFER_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[1]) |-> ($past(xfer_busy, 2) && !$past(xfer_busy))); // R6

  AST_COMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[0] && !$fell(compute_busy)) |=> !irq_flags[0]); // R7

  AST_XFER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[1] && !$fell(xfer_busy)) |=> !irq_flags[1]); // R7

  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[1] && $fell(xfer_busy)) |=> irq_flags[1]); // R8

endmodule

bind acc_interval_seq acc_interval_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .compute_busy (compute_busy),
  .xfer_busy    (xfer_busy),
  .clr_wr       (clr_wr),
  .clr_bits     (clr_bits),
  .irq_flags    (irq_flags)
);

// File: tb/acc_interval_seq_test.sv
`timescale 1ns/1ps
module acc_interval_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick_32k = 1'b0;
  logic [7:0] grp_count = 8'd1;
  logic [1:0] grp_size_sel = 2'd0;
  logic       compute_busy;
  logic       xfer_busy;
  logic       clr_wr = 1'b0;
  logic [1:0] clr_bits = 2'b00;
  logic [1:0] irq_flags;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int cyc = 0;

  always #2.5 clk = ~clk;

  acc_interval_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick_32k(tick_32k),
    .grp_count(grp_count), .grp_size_sel(grp_size_sel),
    .compute_busy(compute_busy), .xfer_busy(xfer_busy),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Slow-clock strobe: high once every tick_div cycles.
  always @(negedge clk) begin
    cyc++;
    tick_32k = ((cyc % tick_div) == 0);
  end

  // Monitor sampled 2 ns after each rising edge.
  bit m_pc = 0, m_px = 0, have_prev = 0;
  int comp_len = 0, xfer_len = 0, since = 0, last_n = 0, n_int = 0;
  int mcyc = 0, last_rise = 0;

  always @(posedge clk) begin
    #2;
    mcyc++;
    if (!rst_n || !enable) begin
      since = 0; have_prev = 0; comp_len = 0; xfer_len = 0;
    end else begin
      if (compute_busy) comp_len++;
      if (xfer_busy) xfer_len++;
      if (compute_busy && !m_pc) begin
        since++;
        if (have_prev) check(mcyc - last_rise == 13 * tick_div, "R1 period", mcyc - last_rise, 13 * tick_div);
        have_prev = 1;
        last_rise = mcyc;
      end
      if (!compute_busy && m_pc) begin
        check(comp_len == 4, "R2 width", comp_len, 4);
        comp_len = 0;
      end
      if (xfer_busy && !m_px) begin
        check(m_pc && !compute_busy, "R5 start", int'(compute_busy), 0);
        last_n = since;
        since = 0;
        n_int++;
      end
      if (!xfer_busy && m_px) begin
        check(xfer_len == 2, "R5 width", xfer_len, 2);
        xfer_len = 0;
      end
    end
    m_pc = compute_busy;
    m_px = xfer_busy;
  end

  task automatic wait_fall_comp();
    bit p;
    do begin
      p = compute_busy;
      @(negedge clk);
    end while (!(p && !compute_busy));
  endtask

  task automatic wait_fall_xfer();
    bit p;
    do begin
      p = xfer_busy;
      @(negedge clk);
    end while (!(p && !xfer_busy));
  endtask

  task automatic run_cfg(input int s, input int p, input string req);
    int exp = ((s == 0) ? 1 : s) * (42 << p);
    int base;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    grp_count = 8'(s);
    grp_size_sel = 2'(p);
    enable = 1'b1;
    base = n_int;
    for (int k = 1; k <= 2; k++) begin
      wait (n_int == base + k);
      @(negedge clk);
      check(last_n == exp, req, last_n, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(compute_busy == 0, "R9 reset compute", int'(compute_busy), 0);
    check(xfer_busy == 0, "R9 reset xfer", int'(xfer_busy), 0);
    check(irq_flags == 0, "R9 reset flags", int'(irq_flags), 0);
    check(irq == 0, "R10 reset irq", int'(irq), 0);

    // R1: first period starts at the first tick after enable
    grp_count = 8'd1; grp_size_sel = 2'd0;
    enable = 1'b1;
    @(negedge clk);
    check(compute_busy == 1, "R1 first sample", int'(compute_busy), 1);
    check(irq_flags[0] == 0, "R6 no flag on rise", int'(irq_flags[0]), 0);

    // R6: flag set one edge after the fall
    wait_fall_comp();
    check(irq_flags[0] == 0, "R6 flag timing", int'(irq_flags[0]), 0);
    @(negedge clk);
    check(irq_flags[0] == 1, "R6 flag on fall", int'(irq_flags[0]), 1);
    check(irq == 1, "R10 irq high", int'(irq), 1);

    // R7: write-one-to-clear of bit 0, bit 1 untouched
    clr_wr = 1'b1; clr_bits = 2'b01;
    @(negedge clk);
    clr_wr = 1'b0; clr_bits = 2'b00;
    check(irq_flags[0] == 0, "R7 clear", int'(irq_flags[0]), 0);
    check(irq == 0, "R10 irq low", int'(irq), 0);

    // R8: clear meets a transfer falling edge
    wait_fall_xfer();
    check(irq_flags[1] == 0, "R6 xfer flag timing", int'(irq_flags[1]), 0);
    clr_wr = 1'b1; clr_bits = 2'b10;
    @(negedge clk);
    clr_wr = 1'b0; clr_bits = 2'b00;
    check(irq_flags[1] == 1, "R8 collision", int'(irq_flags[1]), 1);
    clr_wr = 1'b1; clr_bits = 2'b10;
    @(negedge clk);
    clr_wr = 1'b0; clr_bits = 2'b00;
    check(irq_flags[1] == 0, "R7 clear xfer", int'(irq_flags[1]), 0);

    // R9: disable mid-interval, stay idle, restart from zero
    repeat (60) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!compute_busy && !xfer_busy, "R9 idle on disable", int'({compute_busy, xfer_busy}), 0);
    begin
      int rises = 0;
      bit p = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (compute_busy && !p) rises++;
        p = compute_busy;
      end
      check(rises == 0, "R9 no sampling while off", rises, 0);
    end
    enable = 1'b1;
    begin
      int base = n_int;
      wait (n_int == base + 1);
      @(negedge clk);
      check(last_n == 42, "R9 restart full interval", last_n, 42);
    end

    // R3 and R11: sweep size codes and group counts, two intervals each
    for (int p = 0; p < 4; p++) begin
      run_cfg(1, p, "R3 R11 groups 1");
      run_cfg(3, p, "R3 R11 groups 3");
    end

    // R4: zero group count
    run_cfg(0, 1, "R4 zero groups");

    // R1: sparse ticks stretch the period
    enable = 1'b0;
    @(negedge clk);
    tick_div = 3;
    run_cfg(1, 0, "R1 sparse ticks");

    enable = 1'b0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule